// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block gathers nine level-sensitive interrupt sources and drives three interrupt request outputs toward an upstream controller. Each raw source first passes through a two-flop synchroniser. A per-source polarity bit then turns it into an internal "asserted" level, where 1 means active high and 0 means active low. Every output line has its own 32-bit control word. The low field of that word enables sources onto the line. The upper field shows which sources are pending on that line, and software clears a pending bit by writing a one to it.

Software reaches the registers through a plain register bus. A write happens in any cycle with `bus_we` high. Read data is combinational from `bus_addr`. A pending source is serviced by writing back the line's enable field with a one in that source's status bit. A source that is still asserted becomes pending again at once, as level sensitivity requires. Initialisation writes 0x01FF0000 to each line word.

Top module: `lir_top`

## Requirements
- R1: While reset is held, the polarity word, every enable field and every pending field read as 0 and all three outputs are low.
- R2: The word at byte offset 0x0 holds polarity in bits 0 to 8, one bit per source. A 1 means source k is asserted when its input is high; a 0 means asserted when low. A new polarity takes effect at the clock edge after the write.
- R3: Line n (0 to 2) owns the word at byte offset 0x4 + 4*n. Bits 0 to 8 are the enables for sources 0 to 8 and take the written value. Bits 16 to 24 report pending for sources 0 to 8. All other bits read 0.
- R4: A change on a raw source input first affects a pending bit at the third rising clock edge after the change.
- R5: Pending bit k of every line is set at each clock edge where normalised source k is asserted, whatever the enables are. It stays set until acknowledged.
- R6: Writing 1 to bit 16+k of a line word clears pending k on that line. Writing 0 to a status bit leaves it unchanged. If the source is asserted in the same cycle as the acknowledge, the bit stays set.
- R7: Output n is high exactly when some source is both pending and enabled in line word n. This takes no added clock delay after the register state.
- R8: After 0x01FF0000 is written to a line word while no source is asserted, that word reads 0 and its output is low.
- R9: A byte address above 0xC, or one with bits 1:0 not zero, reads 0, and a write to it changes no polarity or enable bit.
- R10: An acknowledge or enable write to one line leaves the other lines' pending and enable fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 9 | Raw asynchronous interrupt sources |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 3 | Interrupt request outputs, active high |

## Verification
Some behaviours are checked by assertions on every cycle:
- a normalised asserted source sets its pending bit on all lines;
- a pending bit holds unless acknowledged;
- an acknowledge with the source idle clears it;
- an output is low with no enables and never high without a pending bit;
- line-word writes load the enable field;
- stray-address writes leave configuration untouched.

Other behaviours only the scenarios and the cycle-by-cycle reference model can show:
- the exact three-edge latency through the synchroniser;
- polarity of active-low sources;
- set winning over acknowledge;
- the initialisation write;
- line independence;
- read-back of all register fields under random traffic.

// File: rtl/lir_pkg.sv
package lir_pkg;
  localparam int LIR_NSRC     = 9;
  localparam int LIR_NLINES   = 3;
  localparam int LIR_DW       = 32;
  localparam int LIR_AW       = 6;
  localparam int LIR_STAT_LSB = 16;

  // byte offset of the control word for output line n
  function automatic int unsigned line_offset(input int unsigned n);
    return 32'd4 + 32'd4 * n;
  endfunction

  // byte offset of the polarity word
  function automatic int unsigned pol_offset();
    return 32'd0;
  endfunction
endpackage

// File: rtl/lir_sync.sv
module lir_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/lir_norm.sv
module lir_norm #(
  parameter int W = 9
) (
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] active_o
);
  // per source: high-active passes the level, low-active inverts it
  for (genvar k = 0; k < W; k++) begin : g_bit
    assign active_o[k] = pol_i[k] ? lvl_i[k] : ~lvl_i[k];
  end
endmodule

// File: rtl/lir_line.sv
module lir_line #(
  parameter int NSRC = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [NSRC-1:0] wr_en_i,
  input  logic [NSRC-1:0] wr_ack_i,
  input  logic [NSRC-1:0] active_i,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] pend_o,
  output logic            irq_o
);
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] ack_eff;

  assign ack_eff = wr_i ? wr_ack_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (wr_i) en_q <= wr_en_i;
      // a fresh set overrides an acknowledge in the same cycle
      pend_q <= (pend_q & ~ack_eff) | active_i;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & en_q);
endmodule

// File: rtl/lir_top.sv
module lir_top
  import lir_pkg::*;
#(
  parameter int NSRC     = LIR_NSRC,
  parameter int NLINES   = LIR_NLINES,
  parameter int DW       = LIR_DW,
  parameter int AW       = LIR_AW,
  parameter int STAT_LSB = LIR_STAT_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NLINES-1:0] irq_o
);
  localparam int FLAT_W = NSRC * NLINES;

  logic [NSRC-1:0]   src_sync;
  logic [NSRC-1:0]   src_active;
  logic [NSRC-1:0]   pol_q;
  logic              pol_sel;
  logic [NLINES-1:0] line_sel;
  logic [NLINES-1:0] line_wr;
  logic [FLAT_W-1:0] line_en_flat;
  logic [FLAT_W-1:0] line_pend_flat;

  lir_sync #(.W(NSRC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (src_i),
    .q_o   (src_sync)
  );

  lir_norm #(.W(NSRC)) u_norm (
    .lvl_i    (src_sync),
    .pol_i    (pol_q),
    .active_o (src_active)
  );

  assign pol_sel = (bus_addr == AW'(pol_offset()));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pol_q <= '0;
    else if (bus_we && pol_sel) pol_q <= bus_wdata[NSRC-1:0];
  end

  for (genvar n = 0; n < NLINES; n++) begin : g_line
    assign line_sel[n] = (bus_addr == AW'(line_offset(n)));
    assign line_wr[n]  = bus_we && line_sel[n];

    lir_line #(.NSRC(NSRC)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (line_wr[n]),
      .wr_en_i  (bus_wdata[NSRC-1:0]),
      .wr_ack_i (bus_wdata[STAT_LSB +: NSRC]),
      .active_i (src_active),
      .en_o     (line_en_flat[n*NSRC +: NSRC]),
      .pend_o   (line_pend_flat[n*NSRC +: NSRC]),
      .irq_o    (irq_o[n])
    );
  end

  // read mux: selects are mutually exclusive, unmatched addresses give 0
  always_comb begin
    bus_rdata = '0;
    if (pol_sel) bus_rdata[NSRC-1:0] = pol_q;
    for (int n = 0; n < NLINES; n++) begin
      if (line_sel[n]) begin
        bus_rdata[NSRC-1:0]         = line_en_flat[n*NSRC +: NSRC];
        bus_rdata[STAT_LSB +: NSRC] = line_pend_flat[n*NSRC +: NSRC];
      end
    end
  end
endmodule

// File: rtl/lir_checker.sv
module lir_checker #(
  parameter int NSRC     = 9,
  parameter int NLINES   = 3,
  parameter int DW       = 32,
  parameter int AW       = 6,
  parameter int STAT_LSB = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_we,
  input logic [AW-1:0]          bus_addr,
  input logic [DW-1:0]          bus_wdata,
  input logic [NLINES-1:0]      irq_o,
  input logic [NSRC-1:0]        src_active,
  input logic [NSRC-1:0]        pol_q,
  input logic [NLINES-1:0]      line_wr,
  input logic [NSRC*NLINES-1:0] line_en_flat,
  input logic [NSRC*NLINES-1:0] line_pend_flat
);
  localparam int MAX_OFF = 4 * NLINES;

  logic stray_wr;
  assign stray_wr = bus_we && ((int'(bus_addr) > MAX_OFF) || (bus_addr[1:0] != 2'b00));

  // R9: stray writes leave configuration as it was
  p_stray_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stray_wr |=> ($stable(pol_q) && $stable(line_en_flat)));

  // R2: polarity write loads the field
  p_pol_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == '0) |=> pol_q == $past(bus_wdata[NSRC-1:0]));

  for (genvar n = 0; n < NLINES; n++) begin : g_ln
    // R3: enable field takes the written value
    p_en_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      line_wr[n] |=> line_en_flat[n*NSRC +: NSRC] == $past(bus_wdata[NSRC-1:0]));

    // R7: nothing enabled means the line is quiet
    p_mask_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (line_en_flat[n*NSRC +: NSRC] == '0) |-> !irq_o[n]);

    // R7: a raised line always has some pending source
    p_irq_has_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[n] |-> (line_pend_flat[n*NSRC +: NSRC] != '0));

    for (genvar k = 0; k < NSRC; k++) begin : g_src
      // R5: asserted source becomes pending on every line
      p_pend_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        src_active[k] |=> line_pend_flat[n*NSRC + k]);

      // R5: pending holds unless acknowledged
      p_pend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pend_flat[n*NSRC + k] && !(line_wr[n] && bus_wdata[STAT_LSB + k]))
        |=> line_pend_flat[n*NSRC + k]);

      // R6: acknowledge of an idle source clears it
      p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_wr[n] && bus_wdata[STAT_LSB + k] && !src_active[k])
        |=> !line_pend_flat[n*NSRC + k]);
    end
  end
endmodule

bind lir_top lir_checker #(
  .NSRC(NSRC), .NLINES(NLINES), .DW(DW), .AW(AW), .STAT_LSB(STAT_LSB)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_we         (bus_we),
  .bus_addr       (bus_addr),
  .bus_wdata      (bus_wdata),
  .irq_o          (irq_o),
  .src_active     (src_active),
  .pol_q          (pol_q),
  .line_wr        (line_wr),
  .line_en_flat   (line_en_flat),
  .line_pend_flat (line_pend_flat)
);

// File: tb/lir_top_tb_top.sv
module lir_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  src_i = '0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  lir_top dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [8:0] m_pol = '0;
  logic [8:0] m_en [3] = '{default: '0};
  logic [8:0] m_pend [3] = '{default: '0};
  logic [8:0] m_pipe [$] = '{9'd0, 9'd0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pol = '0;
      foreach (m_en[i]) begin m_en[i] = '0; m_pend[i] = '0; end
      m_pipe = '{9'd0, 9'd0};
    end else begin
      logic [8:0] lvl;
      logic [8:0] act;
      lvl = m_pipe[1];
      act = 9'd0;
      for (int k = 0; k < 9; k++) act[k] = (m_pol[k] == 1'b1) ? lvl[k] : !lvl[k];
      for (int i = 0; i < 3; i++) begin
        logic [8:0] ack;
        ack = 9'd0;
        if (bus_we && int'(bus_addr) == 4 * (i + 1)) begin
          ack = bus_wdata[24:16];
          m_en[i] = bus_wdata[8:0];
        end
        m_pend[i] = (m_pend[i] & ~ack) | act;
      end
      if (bus_we && bus_addr == 6'd0) m_pol = bus_wdata[8:0];
      void'(m_pipe.pop_back());
      m_pipe.push_front(src_i);
    end
  end

  function automatic logic [31:0] m_read(input int a);
    logic [31:0] w;
    w = 32'd0;
    if (a == 0) w[8:0] = m_pol;
    else if (a == 4 || a == 8 || a == 12) begin
      w[8:0]   = m_en[a/4 - 1];
      w[24:16] = m_pend[a/4 - 1];
    end
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    logic [2:0] m_irq;
    for (int i = 0; i < 3; i++) m_irq[i] = |(m_pend[i] & m_en[i]);
    check("R7 irq", {29'd0, irq_o}, {29'd0, m_irq});
    if (bus_addr == 6'd0) check("R2 rdata", bus_rdata, m_read(0));
    else if (bus_addr == 6'd4 || bus_addr == 6'd8 || bus_addr == 6'd12)
      check("R3 rdata", bus_rdata, m_read(int'(bus_addr)));
    else check("R9 rdata", bus_rdata, m_read(int'(bus_addr)));
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_we = 1'b1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); #1;
    bus_we = 1'b0; bus_addr = 6'(a);
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] r;
    idle(3);
    rd(4, r);
    check("R1 reset line word", r, 32'd0);
    check("R1 reset irq", {29'd0, irq_o}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // all sources active high, inputs low, then initialise lines
    wr(0, 32'h0000_01FF);
    for (int i = 1; i <= 3; i++) wr(4 * i, 32'h01FF_0000);
    rd(8, r);
    check("R8 init clears line1", r, 32'd0);
    check("R8 init irq low", {29'd0, irq_o}, 32'd0);

    // R4: latency through synchroniser for source 3
    @(negedge clk); #1 src_i[3] = 1'b1;
    @(negedge clk); #1;
    @(negedge clk); #2 check("R4 not yet after 2 edges", {31'd0, bus_rdata[19]}, 32'd0);
    @(negedge clk); #2 check("R4 set after 3 edges", {31'd0, bus_rdata[19]}, 32'd1);

    // R7: enable source 3 on line 1 only
    wr(8, 32'h0000_0008);
    rd(8, r);
    check("R7 line1 raised", {29'd0, irq_o}, 32'd2);

    // R6: acknowledge while source still asserted keeps it pending
    wr(4, 32'h0008_0000);
    rd(4, r);
    check("R6 set wins over ack", {31'd0, r[19]}, 32'd1);

    // drop source, then ack line 0 only
    src_i[3] = 1'b0;
    idle(4);
    wr(4, 32'h0008_0000);
    rd(4, r);
    check("R6 ack clears line0", {31'd0, r[19]}, 32'd0);
    rd(8, r);
    check("R10 line1 untouched", r, 32'h0008_0008);
    wr(8, 32'h0000_0008);
    rd(8, r);
    check("R6 zero status write keeps pending", r, 32'h0008_0008);
    wr(8, 32'h0008_0000);
    check("R7 line low after ack", {29'd0, irq_o}, 32'd0);

    // R2: source 5 active low with input low becomes pending
    wr(0, 32'h0000_01DF);
    idle(2);
    rd(12, r);
    check("R2 active-low pending", {31'd0, r[21]}, 32'd1);
    wr(0, 32'h0000_01FF);
    for (int i = 1; i <= 3; i++) wr(4 * i, 32'h01FF_0000);

    // R9: stray addresses
    wr(16, 32'hFFFF_FFFF);
    wr(6, 32'hFFFF_FFFF);
    rd(16, r);
    check("R9 read above range", r, 32'd0);
    rd(0, r);
    check("R9 polarity untouched", r, 32'h0000_01FF);
    rd(4, r);
    check("R9 enables untouched", r, 32'd0);

    // random traffic compared every clock by the model
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #1;
      if ($urandom_range(0, 3) == 0) src_i = 9'($urandom);
      bus_we = ($urandom_range(0, 2) == 0);
      case ($urandom_range(0, 5))
        0: bus_addr = 6'd0;
        1: bus_addr = 6'd4;
        2: bus_addr = 6'd8;
        3: bus_addr = 6'd12;
        4: bus_addr = 6'd20;
        default: bus_addr = 6'd6;
      endcase
      bus_wdata = $urandom;
    end
    @(negedge clk); #1 bus_we = 1'b0;
    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule